// File: doc/BRIEF.md
# TFT Display Timing Generator

This block drives the control side of a TFT panel. It divides the bus clock down to a pixel clock and a one-cycle pixel enable. From these it walks the horizontal and vertical sequences of sync, back porch, active and front porch. It then emits horizontal sync, vertical sync, data enable and an optional line-end strobe, each with its own polarity control. A downstream pixel path gets the pixel enable, an unpolarized "active" qualifier and a gated data output. Software status is exposed as two 2-bit phase codes and a line counter that counts down across the visible lines.

Every sync, porch and size field holds its length minus one. The divider value and all geometry fields are captured into shadow registers while video is off, and again at each frame boundary. A change written in the middle of a frame therefore only takes effect on the next frame. Polarity, edge-select and line-end-enable controls take effect at once. Clearing the video enable forces every output low and parks both sequencers at the first vertical-sync pixel.

Top module: `tft_timing_gen`

## Requirements
- R1: One pixel lasts 2*(clk_div+1) bus cycles, and a clk_div of 0 behaves as 1. The pixel clock is low for the first half of each pixel and high for the second half. pclk_edge_sel=1 inverts it. pix_tick_o is high in the last bus cycle of each pixel.
- R2: Horizontal phases run in the order sync, back porch, active, front porch, lasting hsync_len+1, hback_len+1, hactive_len+1 and hfront_len+1 pixels. h_phase_o codes them as 00 sync, 01 back porch, 10 active, 11 front porch.
- R3: Vertical phases run in the same order, lasting vsync_len+1, vback_len+1, vactive_last+1 and vfront_len+1 lines, with the same codes on v_phase_o.
- R4: Before polarity, hsync_o is 1 exactly in the horizontal sync phase and vsync_o is 1 exactly in the vertical sync phase.
- R5: de_o and pix_active_o are 1 exactly when both phases are active. Before polarity, pix_data_o equals pix_data_i while active and is 0 otherwise.
- R6: When line_end_en=1, lend_o is 1 for the first front-porch pixel of every vertically active line. When line_end_en=0, lend_o is never asserted.
- R7: line_cnt_o reads vactive_last minus the active-line index during vertical active, and vactive_last otherwise.
- R8: pol_hsync, pol_vsync, pol_de, pol_data and pol_lend each invert their output when 1. pix_active_o is never inverted.
- R9: The divider and geometry inputs are sampled only at a frame boundary or while video is off. A mid-frame change leaves the current frame untouched.
- R10: With video_en=0, every output is 0 and both phases read 00. Enabling again starts at the first vertical-sync pixel.
- R11: A synchronous active-low reset leaves all outputs at 0 and both phase codes at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| video_en | input | 1 | Master enable for all outputs |
| clk_div | input | DIV_W | Pixel clock divider value |
| hsync_len | input | HSW_W | Horizontal sync width minus one |
| hback_len | input | HBP_W | Horizontal back porch minus one |
| hactive_len | input | HCNT_W | Active pixels per line minus one |
| hfront_len | input | HFP_W | Horizontal front porch minus one |
| vsync_len | input | VSW_W | Vertical sync lines minus one |
| vback_len | input | VBP_W | Vertical back porch lines minus one |
| vactive_last | input | VCNT_W | Active lines minus one |
| vfront_len | input | VFP_W | Vertical front porch lines minus one |
| line_end_en | input | 1 | Enables the line-end strobe |
| pclk_edge_sel | input | 1 | Inverts the pixel clock output |
| pol_hsync | input | 1 | Inverts hsync_o |
| pol_vsync | input | 1 | Inverts vsync_o |
| pol_de | input | 1 | Inverts de_o |
| pol_data | input | 1 | Inverts pix_data_o |
| pol_lend | input | 1 | Inverts lend_o |
| pix_data_i | input | DATA_W | Pixel data from the fetch path |
| pclk_o | output | 1 | Pixel clock |
| pix_tick_o | output | 1 | One bus cycle per pixel, at its end |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| lend_o | output | 1 | Line-end strobe |
| pix_active_o | output | 1 | Unpolarized active-pixel qualifier |
| pix_data_o | output | DATA_W | Gated pixel data |
| h_phase_o | output | 2 | Horizontal phase code |
| v_phase_o | output | 2 | Vertical phase code |
| line_cnt_o | output | VCNT_W | Down-counting active line counter |

## Verification
A wrong horizontal count shows up on h_phase_o and hsync_o within one pixel of the fault, and it shifts every later sync edge. A wrong vertical count or a missed shadow capture first appears at the next line or frame boundary, on v_phase_o, vsync_o and line_cnt_o. A divider fault changes the pixel length and so skews pclk_o and pix_tick_o on the very next pixel. For that reason the bench compares every output in every bus cycle against a per-pixel model built from the phase lengths, across frames with different geometry, polarity and divider settings.

// File: rtl/tft_timing_pkg.sv
`timescale 1ns/1ps
// Shared types for the TFT timing generator.
// Assumes phase codes are decoded by software status reads, so values are fixed.
package tft_timing_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'b00,
        PH_BACK   = 2'b01,
        PH_ACTIVE = 2'b10,
        PH_FRONT  = 2'b11
    } tft_phase_e;

    // Phase order is sync, back porch, active, front porch, then sync again.
    function automatic tft_phase_e next_phase(input tft_phase_e ph);
        return tft_phase_e'(ph + 2'd1);
    endfunction

endpackage

// File: rtl/tft_pclk_div.sv
`timescale 1ns/1ps
// Pixel clock divider.
// Toggles a raw pixel clock every (div+1) bus cycles and pulses pix_tick in the
// last bus cycle of each pixel (raw clock high, counter at limit).
// Assumes div is stable except when the counter is at zero or run is low.
module tft_pclk_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             pclk_raw,
    output logic             pix_tick
);

    logic [DIV_W-1:0] half_cnt;
    logic [DIV_W-1:0] eff_div;

    // Clamp the illegal divider value 0 to the minimum legal value 1.
    assign eff_div  = (div_val == '0) ? DIV_W'(1) : div_val;
    assign pix_tick = run && pclk_raw && (half_cnt == eff_div);

    // Half-period counter and raw clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_cnt <= '0;
            pclk_raw <= 1'b0;
        end else if (half_cnt == eff_div) begin
            half_cnt <= '0;
            pclk_raw <= ~pclk_raw;
        end else begin
            half_cnt <= half_cnt + DIV_W'(1);
        end
    end

    // R1: a pixel ends on the high half, so the raw clock is low afterwards.
    p_tick_then_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_tick |=> !pclk_raw);

    // R1: the half-period counter never passes the effective divider.
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        half_cnt <= eff_div);

endmodule

// File: rtl/tft_phase_seq.sv
`timescale 1ns/1ps
// Four-phase sequencer used for both axes.
// On each step it counts within the current phase and advances to the next
// phase after (limit+1) steps. wrap marks the step that leaves the front porch.
// Assumes limits only change while run is low or on the wrap step.
module tft_phase_seq
    import tft_timing_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] lim_sync,
    input  logic [CNT_W-1:0] lim_back,
    input  logic [CNT_W-1:0] lim_active,
    input  logic [CNT_W-1:0] lim_front,
    output tft_phase_e       phase,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] cur_lim;

    // Select the length limit of the phase in progress.
    always_comb begin
        unique case (phase)
            PH_SYNC:   cur_lim = lim_sync;
            PH_BACK:   cur_lim = lim_back;
            PH_ACTIVE: cur_lim = lim_active;
            default:   cur_lim = lim_front;
        endcase
    end

    assign wrap = step && (phase == PH_FRONT) && (cnt == cur_lim);

    // Position counter and phase advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (cnt == cur_lim) begin
                phase <= next_phase(phase);
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R2: without a step the position holds.
    p_hold_without_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> ($stable(phase) && $stable(cnt)));

    // R3: the count never leaves the current phase's length.
    p_cnt_in_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cur_lim);

endmodule

// File: rtl/tft_timing_gen.sv
`timescale 1ns/1ps
// TFT display timing generator (top).
// Shadows the divider and geometry at frame boundaries, runs the pixel divider
// and the two phase sequencers, and forms polarized panel outputs and status.
// Assumes software writes geometry at any time; it takes effect at next frame.
module tft_timing_gen
    import tft_timing_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int HSW_W  = 8,
    parameter int HBP_W  = 7,
    parameter int HCNT_W = 11,
    parameter int HFP_W  = 8,
    parameter int VSW_W  = 6,
    parameter int VBP_W  = 8,
    parameter int VCNT_W = 10,
    parameter int VFP_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              video_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [HSW_W-1:0]  hsync_len,
    input  logic [HBP_W-1:0]  hback_len,
    input  logic [HCNT_W-1:0] hactive_len,
    input  logic [HFP_W-1:0]  hfront_len,
    input  logic [VSW_W-1:0]  vsync_len,
    input  logic [VBP_W-1:0]  vback_len,
    input  logic [VCNT_W-1:0] vactive_last,
    input  logic [VFP_W-1:0]  vfront_len,
    input  logic              line_end_en,
    input  logic              pclk_edge_sel,
    input  logic              pol_hsync,
    input  logic              pol_vsync,
    input  logic              pol_de,
    input  logic              pol_data,
    input  logic              pol_lend,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              pclk_o,
    output logic              pix_tick_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              lend_o,
    output logic              pix_active_o,
    output logic [DATA_W-1:0] pix_data_o,
    output logic [1:0]        h_phase_o,
    output logic [1:0]        v_phase_o,
    output logic [VCNT_W-1:0] line_cnt_o
);

    // Shadowed configuration.
    logic [DIV_W-1:0]  sh_div;
    logic [HSW_W-1:0]  sh_hs;
    logic [HBP_W-1:0]  sh_hb;
    logic [HCNT_W-1:0] sh_ha;
    logic [HFP_W-1:0]  sh_hf;
    logic [VSW_W-1:0]  sh_vs;
    logic [VBP_W-1:0]  sh_vb;
    logic [VCNT_W-1:0] sh_vl;
    logic [VFP_W-1:0]  sh_vf;

    logic              pclk_raw;
    logic              pix_tick;
    tft_phase_e        h_phase;
    tft_phase_e        v_phase;
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic              h_wrap;
    logic              frame_wrap;
    logic              de_int;
    logic              lend_int;

    // Capture configuration while idle or on the step that ends a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div <= '0; sh_hs <= '0; sh_hb <= '0; sh_ha <= '0; sh_hf <= '0;
            sh_vs  <= '0; sh_vb <= '0; sh_vl <= '0; sh_vf <= '0;
        end else if (!video_en || frame_wrap) begin
            sh_div <= clk_div;
            sh_hs  <= hsync_len;
            sh_hb  <= hback_len;
            sh_ha  <= hactive_len;
            sh_hf  <= hfront_len;
            sh_vs  <= vsync_len;
            sh_vb  <= vback_len;
            sh_vl  <= vactive_last;
            sh_vf  <= vfront_len;
        end
    end

    tft_pclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (video_en),
        .div_val  (sh_div),
        .pclk_raw (pclk_raw),
        .pix_tick (pix_tick)
    );

    tft_phase_seq #(.CNT_W(HCNT_W)) u_hseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (video_en),
        .step       (pix_tick),
        .lim_sync   (HCNT_W'(sh_hs)),
        .lim_back   (HCNT_W'(sh_hb)),
        .lim_active (sh_ha),
        .lim_front  (HCNT_W'(sh_hf)),
        .phase      (h_phase),
        .cnt        (h_cnt),
        .wrap       (h_wrap)
    );

    tft_phase_seq #(.CNT_W(VCNT_W)) u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (video_en),
        .step       (h_wrap),
        .lim_sync   (VCNT_W'(sh_vs)),
        .lim_back   (VCNT_W'(sh_vb)),
        .lim_active (sh_vl),
        .lim_front  (VCNT_W'(sh_vf)),
        .phase      (v_phase),
        .cnt        (v_cnt),
        .wrap       (frame_wrap)
    );

    // Decode unpolarized data-enable and line-end strobe from the phases.
    always_comb begin
        de_int   = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        lend_int = line_end_en && (h_phase == PH_FRONT) && (h_cnt == '0)
                   && (v_phase == PH_ACTIVE);
    end

    // Apply polarity and the master enable to every panel output.
    always_comb begin
        pclk_o       = video_en & (pclk_raw ^ pclk_edge_sel);
        pix_tick_o   = pix_tick;
        hsync_o      = video_en & ((h_phase == PH_SYNC) ^ pol_hsync);
        vsync_o      = video_en & ((v_phase == PH_SYNC) ^ pol_vsync);
        de_o         = video_en & (de_int ^ pol_de);
        lend_o       = video_en & (lend_int ^ pol_lend);
        pix_active_o = video_en & de_int;
        pix_data_o   = video_en ? ((de_int ? pix_data_i : '0) ^ {DATA_W{pol_data}})
                                : '0;
    end

    // Status: phase codes and the down-counting active line counter.
    always_comb begin
        h_phase_o  = h_phase;
        v_phase_o  = v_phase;
        line_cnt_o = (v_phase == PH_ACTIVE) ? (sh_vl - v_cnt) : sh_vl;
    end

    // R9: outside a frame boundary the running geometry never changes.
    p_shadow_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && !frame_wrap) |=> ($stable(sh_div) && $stable(sh_ha)
            && $stable(sh_vl) && $stable(sh_hs) && $stable(sh_vs)));

    // R10: disabling video parks both sequencers at the first sync pixel.
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> (h_phase == PH_SYNC && v_phase == PH_SYNC
            && h_cnt == '0 && v_cnt == '0));

    // R7: the line counter never exceeds the active line limit.
    p_line_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt_o <= sh_vl);

endmodule

// File: tb/tft_timing_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task builds the expected per-bus-cycle outputs of
// whole frames from phase lengths; a monitor pops and compares each cycle.
module tft_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        video_en;
    logic [9:0]  clk_div;
    logic [7:0]  hsync_len;
    logic [6:0]  hback_len;
    logic [10:0] hactive_len;
    logic [7:0]  hfront_len;
    logic [5:0]  vsync_len;
    logic [7:0]  vback_len;
    logic [9:0]  vactive_last;
    logic [7:0]  vfront_len;
    logic        line_end_en, pclk_edge_sel;
    logic        pol_hsync, pol_vsync, pol_de, pol_data, pol_lend;
    logic [7:0]  pix_data_i;
    logic        pclk_o, pix_tick_o, hsync_o, vsync_o, de_o, lend_o, pix_active_o;
    logic [7:0]  pix_data_o;
    logic [1:0]  h_phase_o, v_phase_o;
    logic [9:0]  line_cnt_o;

    always #10 clk = ~clk;

    tft_timing_gen u_tft_timing_gen (
        .clk(clk), .rst_n(rst_n), .video_en(video_en), .clk_div(clk_div),
        .hsync_len(hsync_len), .hback_len(hback_len), .hactive_len(hactive_len),
        .hfront_len(hfront_len), .vsync_len(vsync_len), .vback_len(vback_len),
        .vactive_last(vactive_last), .vfront_len(vfront_len),
        .line_end_en(line_end_en), .pclk_edge_sel(pclk_edge_sel),
        .pol_hsync(pol_hsync), .pol_vsync(pol_vsync), .pol_de(pol_de),
        .pol_data(pol_data), .pol_lend(pol_lend), .pix_data_i(pix_data_i),
        .pclk_o(pclk_o), .pix_tick_o(pix_tick_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .lend_o(lend_o),
        .pix_active_o(pix_active_o), .pix_data_o(pix_data_o),
        .h_phase_o(h_phase_o), .v_phase_o(v_phase_o), .line_cnt_o(line_cnt_o)
    );

    typedef struct {
        logic       pclk, tick, hs, vs, de, act, le;
        logic [1:0] hp, vp;
        logic [9:0] lc;
        logic [7:0] d;
        string      ctx;
    } exp_t;

    exp_t q[$];
    exp_t mx;
    int   n_chk  = 0;
    int   n_fail = 0;

    // Geometry sets: 0 = base, 1 = mid-frame replacement, 2 = minimum fields.
    int c_div [3] = '{1, 2, 0};
    int c_hs  [3] = '{0, 1, 0};
    int c_hb  [3] = '{1, 0, 0};
    int c_ha  [3] = '{3, 4, 2};
    int c_hf  [3] = '{1, 2, 0};
    int c_vs  [3] = '{0, 1, 0};
    int c_vb  [3] = '{1, 0, 0};
    int c_vl  [3] = '{2, 3, 1};
    int c_vf  [3] = '{0, 1, 0};

    task automatic cmp(input string tag, input string ctx,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, ctx, act, exp);
        end
    endtask

    task automatic apply_cfg(input int k);
        clk_div      = 10'(c_div[k]);
        hsync_len    = 8'(c_hs[k]);
        hback_len    = 7'(c_hb[k]);
        hactive_len  = 11'(c_ha[k]);
        hfront_len   = 8'(c_hf[k]);
        vsync_len    = 6'(c_vs[k]);
        vback_len    = 8'(c_vb[k]);
        vactive_last = 10'(c_vl[k]);
        vfront_len   = 8'(c_vf[k]);
    endtask

    // Driver: expected outputs of one frame of geometry k, one item per bus cycle.
    task automatic push_frame(input int k, input string ctx);
        int eff, per;
        int hl [4];
        int vl [4];
        exp_t it;
        eff = (c_div[k] == 0) ? 1 : c_div[k];   // R1 clamp
        per = 2 * (eff + 1);
        hl  = '{c_hs[k] + 1, c_hb[k] + 1, c_ha[k] + 1, c_hf[k] + 1};
        vl  = '{c_vs[k] + 1, c_vb[k] + 1, c_vl[k] + 1, c_vf[k] + 1};
        for (int vp = 0; vp < 4; vp++)
            for (int vi = 0; vi < vl[vp]; vi++)
                for (int hp = 0; hp < 4; hp++)
                    for (int hi = 0; hi < hl[hp]; hi++)
                        for (int s = 0; s < per; s++) begin
                            it.ctx  = ctx;
                            it.pclk = (s >= per / 2) ^ pclk_edge_sel;
                            it.tick = (s == per - 1);
                            it.hp   = 2'(hp);
                            it.vp   = 2'(vp);
                            it.hs   = (hp == 0) ^ pol_hsync;
                            it.vs   = (vp == 0) ^ pol_vsync;
                            it.act  = (hp == 2) && (vp == 2);
                            it.de   = it.act ^ pol_de;
                            it.le   = (line_end_en && hp == 3 && hi == 0 && vp == 2)
                                      ^ pol_lend;
                            it.lc   = (vp == 2) ? 10'(c_vl[k] - vi) : 10'(c_vl[k]);
                            it.d    = (it.act ? pix_data_i : 8'h00) ^ {8{pol_data}};
                            q.push_back(it);
                        end
    endtask

    // Monitor: compare every bus cycle away from the clock edges.
    always @(negedge clk) begin
        #2;
        if (q.size() > 0) begin
            mx = q.pop_front();
            cmp("R1 pclk",        mx.ctx, 32'(pclk_o),       32'(mx.pclk));
            cmp("R1 tick",        mx.ctx, 32'(pix_tick_o),   32'(mx.tick));
            cmp("R2 h_phase",     mx.ctx, 32'(h_phase_o),    32'(mx.hp));
            cmp("R3 v_phase",     mx.ctx, 32'(v_phase_o),    32'(mx.vp));
            cmp("R4 R8 hsync",    mx.ctx, 32'(hsync_o),      32'(mx.hs));
            cmp("R4 R8 vsync",    mx.ctx, 32'(vsync_o),      32'(mx.vs));
            cmp("R5 R8 de",       mx.ctx, 32'(de_o),         32'(mx.de));
            cmp("R5 active",      mx.ctx, 32'(pix_active_o), 32'(mx.act));
            cmp("R5 R8 data",     mx.ctx, 32'(pix_data_o),   32'(mx.d));
            cmp("R6 R8 line_end", mx.ctx, 32'(lend_o),       32'(mx.le));
            cmp("R7 line_cnt",    mx.ctx, 32'(line_cnt_o),   32'(mx.lc));
        end
    end

    // Idle check: every output low, phases 00, line counter follows the input.
    task automatic check_idle(input string ctx);
        @(negedge clk); #2;
        cmp("R10 pclk",  ctx, 32'(pclk_o),  0);
        cmp("R10 tick",  ctx, 32'(pix_tick_o), 0);
        cmp("R10 hsync", ctx, 32'(hsync_o), 0);
        cmp("R10 vsync", ctx, 32'(vsync_o), 0);
        cmp("R10 de",    ctx, 32'(de_o),    0);
        cmp("R10 lend",  ctx, 32'(lend_o),  0);
        cmp("R10 act",   ctx, 32'(pix_active_o), 0);
        cmp("R10 data",  ctx, 32'(pix_data_o), 0);
        cmp("R10 phase", ctx, 32'({h_phase_o, v_phase_o}), 0);
        cmp("R7 idle line_cnt", ctx, 32'(line_cnt_o), 32'(vactive_last));
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        @(posedge clk); #3;
    endtask

    initial begin
        rst_n = 1'b0; video_en = 1'b0;
        line_end_en = 1'b0; pclk_edge_sel = 1'b0;
        pol_hsync = 1'b0; pol_vsync = 1'b0; pol_de = 1'b0;
        pol_data = 1'b0; pol_lend = 1'b0; pix_data_i = 8'h00;
        apply_cfg(0);
        repeat (3) @(posedge clk);
        // R11: reset state.
        @(negedge clk); #2;
        cmp("R11 outputs", "reset", 32'({pclk_o, hsync_o, vsync_o, de_o, lend_o,
            pix_active_o}), 0);
        cmp("R11 phases", "reset", 32'({h_phase_o, v_phase_o}), 0);
        @(posedge clk); #3;
        rst_n = 1'b1;
        @(posedge clk); #3;

        // Run A then B: geometry change mid-frame applies from frame two (R9).
        line_end_en = 1'b1; pix_data_i = 8'hA5;
        apply_cfg(0);
        @(posedge clk); #3;
        push_frame(0, "base frame");
        push_frame(1, "R9 frame after mid-frame change");
        video_en = 1'b1;
        repeat (100) @(posedge clk);
        #3 apply_cfg(1);
        drain();

        // Disable mid-frame, then all polarities inverted, clamp divider (R1, R8).
        video_en = 1'b0;
        check_idle("R10 disabled mid-frame");
        @(posedge clk); #3;
        apply_cfg(2);
        line_end_en = 1'b0; pclk_edge_sel = 1'b1; pix_data_i = 8'h3C;
        pol_hsync = 1'b1; pol_vsync = 1'b1; pol_de = 1'b1;
        pol_data = 1'b1; pol_lend = 1'b1;
        @(posedge clk); #3;
        push_frame(2, "R8 inverted, R1 divider 0, R6 strobe off, R10 restart");
        push_frame(2, "R8 inverted second frame");
        video_en = 1'b1;
        drain();

        // Mixed polarity, restart after disable (R10).
        video_en = 1'b0;
        check_idle("R10 disabled again");
        @(posedge clk); #3;
        apply_cfg(0);
        line_end_en = 1'b1; pclk_edge_sel = 1'b0; pix_data_i = 8'h5A;
        pol_hsync = 1'b1; pol_vsync = 1'b0; pol_de = 1'b0;
        pol_data = 1'b0; pol_lend = 1'b1;
        @(posedge clk); #3;
        push_frame(0, "R8 mixed polarity, R10 restart");
        video_en = 1'b1;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule